// File: doc/BRIEF.md
# Pseudo-SRAM Power-Up and Access Controller

This block sits between a synchronous host and an asynchronous 16-bit pseudo-static RAM. The RAM has two chip selects of opposite polarity, separate output and write enables, and one active-low enable per byte lane. After reset the controller keeps the RAM deselected for the required power-up hold. It then accepts one single-word read or write at a time over a valid/ready request port, and plays each request out on the memory pins with every interval counted in cycles of the system clock.

Every nanosecond limit is a parameter. Each one is turned into a cycle count at elaboration, rounded up against the clock period parameter. Two rules that only appear over many accesses are enforced as well. In a long run of consecutive writes, every pulse after the limit is widened. If the RAM stays selected for too long without a real standby gap, a standby period of one full read-cycle length is forced, so that the RAM's hidden self-refresh keeps running.

Read data comes back as a one-cycle `rsp_valid` pulse. Byte lanes that were not requested read as zero. The memory data bus is split into an output, an output-enable and an input; the pad ring joins them.

Top module: `psram_seq_ctrl`

## Requirements
- R1: After reset, for 200 us (25000 cycles at the default 8 ns clock), `mem_cs1_n` is high, `mem_cs2` is low and `req_ready` is low. `req_ready` first rises between 25000 and 25002 cycles after reset is released.
- R2: A read drives `mem_cs1_n` low, `mem_cs2` high, `mem_we_n` high and `mem_oe_n` low for ceil(70 ns / period) = 9 cycles, with `mem_dq_oe` low.
- R3: A write holds `mem_cs1_n` and `mem_we_n` low for ceil(55 ns / period) = 7 cycles. During that time `mem_dq_oe` is high and `mem_dq_out` is steady, which covers the 30 ns data setup.
- R4: `req_be` bit 0 selects the lower byte (`mem_dq` bits 7:0, `mem_be_n[0]`) and bit 1 selects the upper byte (bits 15:8, `mem_be_n[1]`). A write changes only the enabled lanes. On a read, `rsp_rdata` carries the enabled lanes and zero in the others.
- R5: Consecutive falling edges of `mem_cs1_n` are at least 9 cycles (70 ns) apart, for both reads and writes.
- R6: In an unbroken run of writes, the first 50 use 7-cycle pulses and the 51st and later use ceil(70 ns / period) = 9-cycle pulses. Any read, and any idle cycle with no request, ends the run.
- R7: Between two write pulses, `mem_we_n` stays high for at least ceil(5 ns / period) = 1 cycle.
- R8: Measured from the end of the last deselected run of at least 9 cycles, the RAM is never kept without such a run for 500 cycles (4 us) or longer. Under continuous traffic, `req_ready` drops while a forced standby runs.
- R9: `req_ready` is high only while the controller is idle with all memory strobes inactive. It is low from acceptance until the access ends. Each accepted read produces exactly one `rsp_valid` pulse.
- R10: `mem_dq_oe` is high only during a write pulse and is low before any read starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 23 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte-lane select, bit 0 lower, bit 1 upper |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_rdata | output | 16 | Read data, unselected lanes zero |
| mem_addr | output | 23 | Memory address pins |
| mem_cs1_n | output | 1 | Primary chip select, active low |
| mem_cs2 | output | 1 | Secondary chip select, active high |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_be_n | output | 2 | Byte-lane enables, active low, bit 0 lower |
| mem_dq_out | output | 16 | Data driven toward memory |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_out` |
| mem_dq_in | input | 16 | Data returned from memory |

## Verification
The assertions assume that `rst_n` is synchronous and held for at least one edge. They assume nothing about the host: request fields are latched at acceptance and may change at any other time. `mem_dq_in` only has to be valid on the last read cycle. The bench's memory model answers only while select and output enable are both active. The bench changes requests on the falling clock edge and keeps `req_valid` high through busy periods during streams, which exercises the acceptance gating without ever breaking a write run by accident.

// File: rtl/psq_pkg.sv
package psq_pkg;

    typedef enum logic [2:0] {
        ST_PWR    = 3'd0,
        ST_IDLE   = 3'd1,
        ST_READ   = 3'd2,
        ST_WPULSE = 3'd3,
        ST_WREC   = 3'd4,
        ST_REST   = 3'd5
    } psq_state_e;

    // Round a nanosecond limit up to whole clock cycles.
    function automatic int unsigned ns_to_cyc(input int unsigned ns,
                                              input int unsigned period_ps);
        return (ns * 1000 + period_ps - 1) / period_ps;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/psq_powerup.sv
module psq_powerup #(
    parameter int unsigned COUNT = 25000
) (
    input  logic clk,
    input  logic rst_n,
    output logic done
);
    localparam int unsigned CW = $clog2(COUNT + 1);
    localparam logic [CW-1:0] LAST = CW'(COUNT - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          done;
    } pu_t;

    pu_t q, d;

    always_comb begin
        d = q;
        if (!q.done) begin
            if (q.cnt == LAST) d.done = 1'b1;
            else               d.cnt  = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done = q.done;

    // R1: hold ends only after the full count
    assert_hold_full_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.done) |-> $past(q.cnt) == LAST);
endmodule

// File: rtl/psq_write_streak.sv
module psq_write_streak #(
    parameter int unsigned LIMIT = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_start,
    input  logic run_break,
    output logic long_next
);
    localparam int unsigned CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] SAT = CW'(LIMIT);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } ws_t;

    ws_t q, d;

    always_comb begin
        d = q;
        if (run_break)                  d.cnt = '0;
        else if (wr_start && q.cnt != SAT) d.cnt = q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign long_next = (q.cnt == SAT);

    // R6: a break always restarts the run
    assert_run_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        run_break |=> !long_next);
endmodule

// File: rtl/psq_refresh_guard.sv
module psq_refresh_guard #(
    parameter int unsigned RC     = 9,
    parameter int unsigned WINDOW = 500,
    parameter int unsigned GUARD  = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic desel,
    output logic need_rest
);
    localparam int unsigned WW  = $clog2(WINDOW + 1);
    localparam int unsigned RW  = $clog2(RC + 1);
    localparam logic [WW-1:0] THRESH = WW'(WINDOW - GUARD);
    localparam logic [WW-1:0] WSAT   = WW'(WINDOW);
    localparam logic [RW-1:0] RSAT   = RW'(RC);

    typedef struct packed {
        logic [WW-1:0] busy;
        logic [RW-1:0] gap;
    } rg_t;

    rg_t q, d;

    always_comb begin
        d = q;
        if (desel) begin
            if (q.gap != RSAT) d.gap = q.gap + 1'b1;
        end else begin
            d.gap = '0;
        end
        if (desel && (d.gap == RSAT))  d.busy = '0;
        else if (q.busy != WSAT)       d.busy = q.busy + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign need_rest = (q.busy >= THRESH);

    // R8: a full standby run arrives before the window runs out
    assert_refresh_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy < WSAT);
    // R8: while selected, no standby credit accumulates
    assert_gap_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !desel |=> q.gap == '0);
endmodule

// File: rtl/psram_seq_ctrl.sv
module psram_seq_ctrl
    import psq_pkg::*;
#(
    parameter int unsigned CLK_PS       = 8000,
    parameter int unsigned ADDR_W       = 23,
    parameter int unsigned DATA_W       = 16,
    parameter int unsigned PWRUP_NS     = 200000,
    parameter int unsigned CYCLE_NS     = 70,
    parameter int unsigned WPULSE_NS    = 55,
    parameter int unsigned WLONG_NS     = 70,
    parameter int unsigned WEHIGH_NS    = 5,
    parameter int unsigned DSETUP_NS    = 30,
    parameter int unsigned STREAK_LIMIT = 50,
    parameter int unsigned WINDOW_NS    = 4000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic                     req_write,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    input  logic [DATA_W/8-1:0]      req_be,
    output logic                     rsp_valid,
    output logic [DATA_W-1:0]        rsp_rdata,
    output logic [ADDR_W-1:0]        mem_addr,
    output logic                     mem_cs1_n,
    output logic                     mem_cs2,
    output logic                     mem_oe_n,
    output logic                     mem_we_n,
    output logic [DATA_W/8-1:0]      mem_be_n,
    output logic [DATA_W-1:0]        mem_dq_out,
    output logic                     mem_dq_oe,
    input  logic [DATA_W-1:0]        mem_dq_in
);
    localparam int unsigned LANES = DATA_W / 8;
    localparam int unsigned RC_C  = ns_to_cyc(CYCLE_NS, CLK_PS);
    localparam int unsigned WP_C  = max2(ns_to_cyc(WPULSE_NS, CLK_PS), ns_to_cyc(DSETUP_NS, CLK_PS));
    localparam int unsigned WPL_C = max2(ns_to_cyc(WLONG_NS, CLK_PS), WP_C);
    localparam int unsigned WHP_C = max2(ns_to_cyc(WEHIGH_NS, CLK_PS), 1);
    localparam int unsigned REC_C = max2(WHP_C, (RC_C > WP_C) ? RC_C - WP_C : 1);
    localparam int unsigned PU_C  = ns_to_cyc(PWRUP_NS, CLK_PS);
    localparam int unsigned WIN_C = ns_to_cyc(WINDOW_NS, CLK_PS);
    localparam int unsigned GRD_C = 2 * RC_C + WPL_C + REC_C + 2;
    localparam int unsigned CNT_W = $clog2(max2(max2(RC_C, WPL_C), REC_C) + 1);

    localparam logic [CNT_W-1:0] RC_LAST  = CNT_W'(RC_C - 1);
    localparam logic [CNT_W-1:0] WP_LAST  = CNT_W'(WP_C - 1);
    localparam logic [CNT_W-1:0] WPL_LAST = CNT_W'(WPL_C - 1);
    localparam logic [CNT_W-1:0] REC_LAST = CNT_W'(REC_C - 1);

    typedef struct packed {
        psq_state_e          st;
        logic [CNT_W-1:0]    cnt;
        logic                long_wr;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   wdata;
        logic [LANES-1:0]    be;
        logic                cs1_n;
        logic                cs2;
        logic                oe_n;
        logic                we_n;
        logic                dq_oe;
        logic [LANES-1:0]    be_n;
        logic                rsp_valid;
        logic [DATA_W-1:0]   rdata;
    } ctl_t;

    ctl_t q, d;

    logic pwr_done, need_rest, long_next, wr_start, run_break;

    psq_powerup #(.COUNT(PU_C)) u_pwr (
        .clk  (clk),
        .rst_n(rst_n),
        .done (pwr_done)
    );

    psq_write_streak #(.LIMIT(STREAK_LIMIT)) u_streak (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_start (wr_start),
        .run_break(run_break),
        .long_next(long_next)
    );

    psq_refresh_guard #(.RC(RC_C), .WINDOW(WIN_C), .GUARD(GRD_C)) u_guard (
        .clk      (clk),
        .rst_n    (rst_n),
        .desel    (q.cs1_n),
        .need_rest(need_rest)
    );

    always_comb begin
        d           = q;
        d.rsp_valid = 1'b0;
        wr_start    = 1'b0;
        run_break   = 1'b0;

        unique case (q.st)
            ST_PWR: begin
                if (pwr_done) d.st = ST_IDLE;
            end
            ST_IDLE: begin
                if (need_rest) begin
                    d.st = ST_REST;
                end else if (req_valid) begin
                    d.addr  = req_addr;
                    d.wdata = req_wdata;
                    d.be    = req_be;
                    d.cnt   = '0;
                    if (req_write) begin
                        d.st      = ST_WPULSE;
                        d.long_wr = long_next;
                        wr_start  = 1'b1;
                    end else begin
                        d.st      = ST_READ;
                        run_break = 1'b1;
                    end
                end else begin
                    run_break = 1'b1;
                end
            end
            ST_READ: begin
                if (q.cnt == RC_LAST) begin
                    d.st        = ST_IDLE;
                    d.rsp_valid = 1'b1;
                    for (int i = 0; i < LANES; i++)
                        d.rdata[i*8 +: 8] = q.be[i] ? mem_dq_in[i*8 +: 8] : 8'h00;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_WPULSE: begin
                if (q.cnt == (q.long_wr ? WPL_LAST : WP_LAST)) begin
                    d.st  = ST_WREC;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_WREC: begin
                if (q.cnt == REC_LAST) d.st = ST_IDLE;
                else                   d.cnt = q.cnt + 1'b1;
            end
            ST_REST: begin
                if (!need_rest) d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase

        // Pin levels follow the state being entered, so they are registered.
        d.cs1_n = 1'b1;
        d.cs2   = (d.st != ST_PWR);
        d.oe_n  = 1'b1;
        d.we_n  = 1'b1;
        d.dq_oe = 1'b0;
        d.be_n  = '1;
        if (d.st == ST_READ) begin
            d.cs1_n = 1'b0;
            d.oe_n  = 1'b0;
            d.be_n  = ~d.be;
        end else if (d.st == ST_WPULSE) begin
            d.cs1_n = 1'b0;
            d.we_n  = 1'b0;
            d.dq_oe = 1'b1;
            d.be_n  = ~d.be;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_PWR;
            q.cs1_n <= 1'b1;
            q.cs2   <= 1'b0;
            q.oe_n  <= 1'b1;
            q.we_n  <= 1'b1;
            q.be_n  <= '1;
        end else begin
            q <= d;
        end
    end

    assign req_ready  = (q.st == ST_IDLE) && !need_rest;
    assign rsp_valid  = q.rsp_valid;
    assign rsp_rdata  = q.rdata;
    assign mem_addr   = q.addr;
    assign mem_cs1_n  = q.cs1_n;
    assign mem_cs2    = q.cs2;
    assign mem_oe_n   = q.oe_n;
    assign mem_we_n   = q.we_n;
    assign mem_be_n   = q.be_n;
    assign mem_dq_out = q.wdata;
    assign mem_dq_oe  = q.dq_oe;

    // R1: deselected and not ready until the hold is over
    assert_powerup_desel_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_done |-> (mem_cs1_n && !mem_cs2 && !req_ready));
    // R2: output enable only with a read-shaped select pattern
    assert_read_pins_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (!mem_cs1_n && mem_cs2 && mem_we_n && !mem_dq_oe));
    // R3: write data steady and driven through the pulse
    assert_write_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_dq_out) && mem_dq_oe && !mem_cs1_n));
    // R7: write enable stays high at least one cycle between pulses
    assert_we_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |=> mem_we_n);
    // R9: ready only with all strobes inactive
    assert_ready_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_cs1_n && mem_we_n && mem_oe_n));
    // R10: data bus driven only inside a write pulse
    assert_bus_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> !mem_we_n);
endmodule

// File: tb/psram_seq_ctrl_test.sv
module psram_seq_ctrl_test;
    localparam int PU_C  = 25000;
    localparam int RC_C  = 9;
    localparam int WP_C  = 7;
    localparam int WPL_C = 9;
    localparam int WHP_C = 1;
    localparam int WIN_C = 500;
    localparam int NVEC  = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [22:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        req_ready, rsp_valid;
    logic [15:0] rsp_rdata;
    logic [22:0] mem_addr;
    logic        mem_cs1_n, mem_cs2, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [1:0]  mem_be_n;
    logic [15:0] mem_dq_out, mem_dq_in;

    psram_seq_ctrl uut (.*);

    // Memory model: 16 words, lanes gated by the byte-enable pins.
    logic [15:0] mem [0:15];
    always_comb begin
        mem_dq_in = 16'h0;
        if (!mem_cs1_n && mem_cs2 && !mem_oe_n) begin
            if (!mem_be_n[0]) mem_dq_in[7:0]  = mem[mem_addr[3:0]][7:0];
            if (!mem_be_n[1]) mem_dq_in[15:8] = mem[mem_addr[3:0]][15:8];
        end
    end

    int total = 0, bad = 0;
    int wp_len [0:63];
    int pidx = 0, wl = 0, wh = 0, min_wh = 1000;
    int rd_len = 0, last_rd = 0, sel_gap = 1000, min_sel = 1000, seen_sel = 0;
    int run = 0, span = 0, max_span = 0;
    int early_sel = 0, bus_bad = 0, ready_bad = 0, rsp_cnt = 0, pulses = 0;
    logic pwe = 1'b1, pcs = 1'b1, ready_seen = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!ready_seen && (!mem_cs1_n || mem_cs2)) early_sel++;
            if (req_ready) ready_seen = 1'b1;
            if (!mem_cs1_n && mem_cs2 && !mem_we_n && mem_dq_oe) begin
                if (!mem_be_n[0]) mem[mem_addr[3:0]][7:0]  = mem_dq_out[7:0];
                if (!mem_be_n[1]) mem[mem_addr[3:0]][15:8] = mem_dq_out[15:8];
            end
            if (mem_dq_oe && mem_we_n) bus_bad++;
            if (req_ready && (!mem_cs1_n || !mem_we_n || !mem_oe_n)) ready_bad++;
            if (rsp_valid) rsp_cnt++;
            // write pulse lengths and high gaps
            if (!mem_we_n) begin
                if (pwe && pulses > 0 && wh < min_wh) min_wh = wh;
                wl++;
            end else begin
                if (!pwe) begin
                    if (pidx < 64) wp_len[pidx] = wl;
                    pidx++; pulses++; wl = 0; wh = 0;
                end
                wh++;
            end
            // read strobe length
            if (!mem_oe_n) rd_len++;
            else if (rd_len != 0) begin last_rd = rd_len; rd_len = 0; end
            // select-to-select spacing
            sel_gap++;
            if (pcs && !mem_cs1_n) begin
                if (seen_sel != 0 && sel_gap < min_sel) min_sel = sel_gap;
                seen_sel = 1; sel_gap = 0;
            end
            // refresh window
            if (mem_cs1_n) run++; else run = 0;
            if (run >= RC_C) span = 0; else span++;
            if (span > max_span) max_span = span;
            pwe = mem_we_n; pcs = mem_cs1_n;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic issue(input logic wr, input logic [3:0] a, input logic [1:0] be,
                         input logic [15:0] wd);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = {19'd0, a};
        req_be = be; req_wdata = wd;
        @(posedge clk);
    endtask

    // {write, addr[3:0], be[1:0], wdata[15:0], expected read[15:0]}
    localparam logic [38:0] VEC [0:NVEC-1] = '{
        {1'b1, 4'd1, 2'b11, 16'hA5A5, 16'h0000},
        {1'b0, 4'd1, 2'b11, 16'h0000, 16'hA5A5},
        {1'b1, 4'd1, 2'b01, 16'h773C, 16'h0000},
        {1'b0, 4'd1, 2'b11, 16'h0000, 16'hA53C},
        {1'b1, 4'd1, 2'b10, 16'h99EE, 16'h0000},
        {1'b0, 4'd1, 2'b11, 16'h0000, 16'h993C},
        {1'b1, 4'd2, 2'b11, 16'h1234, 16'h0000},
        {1'b0, 4'd2, 2'b01, 16'h0000, 16'h0034},
        {1'b0, 4'd2, 2'b10, 16'h0000, 16'h1200},
        {1'b0, 4'd1, 2'b11, 16'h0000, 16'h993C}
    };

    initial begin
        automatic int t = 0;
        automatic int rsp_before;
        for (int i = 0; i < 16; i++) mem[i] = 16'h0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: power-up hold
        repeat (100) @(negedge clk);
        check("R1 ready low early in hold", int'(req_ready), 0);
        check("R1 secondary select low in hold", int'(mem_cs2), 0);
        t = 100;
        while (!req_ready && t < PU_C + 50) begin @(negedge clk); t++; end
        check("R1 hold length in range", int'(t >= PU_C && t <= PU_C + 2), 1);
        check("R1 no select during hold", early_sel, 0);

        // Table of reads and writes (R2, R3, R4, R9)
        for (int v = 0; v < NVEC; v++) begin
            rsp_before = rsp_cnt;
            issue(VEC[v][38], VEC[v][37:34], VEC[v][33:32], VEC[v][31:16]);
            @(negedge clk);
            req_valid = 1'b0;
            check("R9 ready low after acceptance", int'(req_ready), 0);
            if (!VEC[v][38]) begin
                while (!rsp_valid) @(negedge clk);
                check("R4 read data by lane", int'(rsp_rdata), int'(VEC[v][15:0]));
                @(negedge clk);
                check("R9 single response per read", rsp_cnt - rsp_before, 1);
            end
        end
        check("R2 read strobe length", last_rd, RC_C);
        check("R3 short write pulse", wp_len[0], WP_C);
        check("R5 select spacing", int'(min_sel >= RC_C), 1);

        // R6: long write stream
        repeat (5) @(negedge clk);
        pidx = 0;
        for (int k = 0; k < 52; k++) issue(1'b1, 4'd5, 2'b11, 16'(k + 16'h4000));
        @(negedge clk); req_valid = 1'b0;
        repeat (15) @(negedge clk);
        check("R6 50th pulse short", wp_len[49], WP_C);
        check("R6 51st pulse widened", wp_len[50], WPL_C);
        check("R6 52nd pulse widened", wp_len[51], WPL_C);
        check("R7 WE high between pulses", int'(min_wh >= WHP_C), 1);
        issue(1'b0, 4'd5, 2'b11, 16'h0);
        @(negedge clk); req_valid = 1'b0;
        while (!rsp_valid) @(negedge clk);
        check("R6 last stream word stored", int'(rsp_rdata), 16'h4000 + 51);

        // R6: after a read the run restarts with short pulses
        pidx = 0;
        issue(1'b1, 4'd6, 2'b11, 16'hBEEF);
        @(negedge clk); req_valid = 1'b0;
        repeat (15) @(negedge clk);
        check("R6 run restarts after read", wp_len[0], WP_C);

        // R8: continuous reads must be broken by a forced standby
        max_span = 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 23'd1; req_be = 2'b11;
        t = 0;
        for (int c = 0; c < 1500; c++) begin
            @(negedge clk);
            if (!req_ready && mem_cs1_n && !rsp_valid) t++;
        end
        req_valid = 1'b0;
        repeat (20) @(negedge clk);
        check("R8 standby window kept", int'(max_span < WIN_C), 1);
        check("R8 forced standby observed", int'(t >= RC_C), 1);
        check("R5 select spacing under stream", int'(min_sel >= RC_C), 1);
        check("R10 bus driven only in pulses", bus_bad, 0);
        check("R9 ready only when quiet", ready_bad, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule